// File: doc/BRIEF.md
# Object Handle Hash Table Engine

This engine keeps a table that maps a 32-bit object handle, qualified by a 5-bit channel number, to a slot. Each slot stores the handle and a packed context word. The context word carries the channel, the engine selector and the instance address. A requester issues one command at a time over a valid/ready request port. An insert places a new entry. A lookup finds the entry for a handle and channel and returns its context word. A remove clears a slot given by its index.

The starting slot comes from a hash. The handle is cut into slices of the hash width, and the slices are combined with XOR. The channel number is then shifted up and XORed in. Collisions are resolved by open addressing with linear probing. The table lives in a synchronous RAM with one entry per slot, and the RAM performs one access per clock. A slot counts as free when its stored handle is zero. After reset, the engine first writes zero to every slot. Every command ends with a single-cycle `rsp_done` that carries the hit and full flags, the slot index and the context word.

Top module: `obj_hash_engine`

## Requirements
- R1: The base hash is the XOR of consecutive HASH_W-bit slices of the handle, taken from bit 0 upward. The last slice is zero-padded at the top.
- R2: The channel number is shifted left by HASH_W-4 and XORed into the base hash. Only the low HASH_W bits are kept, and the result is the start slot.
- R3: Insert probes the start slot, then start+1, and so on, wrapping from the last slot to slot 0. It writes the first slot whose handle is zero. It responds with hit=1, that slot, and the written context word.
- R4: If an insert returns to its start slot without finding a free slot, it responds with full=1, hit=0, the start slot and context 0. It writes nothing.
- R5: When fmt_alt=0, the context word holds instance[19:4] in bits 15:0, the engine in bits 17:16, the channel in bits 28:24, and 1 in bit 31. All other bits are 0.
- R6: When fmt_alt=1, the context word holds instance[19:4] in bits 15:0, the engine in bits 21:20, the channel in bits 28:24, and 0 in bit 31. All other bits are 0. fmt_alt is sampled when the request is accepted.
- R7: Lookup probes in the same order as insert. It hits only on a slot whose handle and channel field (bits 28:24) both match, and returns that slot and its context word. It misses at the first free slot or after a full wrap. A miss returns hit=0, full=0, the start slot and context 0.
- R8: A lookup or insert with handle 0 reads and writes nothing. It responds with hit=0, full=0, the start slot and context 0.
- R9: Remove (op 2) writes zero to both words of slot req_slot. It responds with hit=1, slot req_slot and context 0.
- R10: Op codes are 0 insert, 1 lookup, 2 remove and 3 no-op. A no-op responds with hit=0, full=0, the start slot and context 0. The cycle after an accepted request, req_ready is low. rsp_done is high for exactly one cycle per command, and hit and full are never both 1.
- R11: After reset, req_ready stays low while every slot is cleared, which takes 2^HASH_W cycles. After that, every lookup misses until an insert is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to accept |
| req_op | input | 2 | 0 insert, 1 lookup, 2 remove, 3 no-op |
| req_handle | input | 32 | Object handle |
| req_chan | input | 5 | Channel number |
| req_engine | input | 2 | Engine selector stored in the context word |
| req_inst | input | 20 | Instance address (bits 19:4 are stored) |
| req_slot | input | HASH_W | Slot index for remove |
| fmt_alt | input | 1 | Context word layout select |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_hit | output | 1 | Entry found or written |
| rsp_full | output | 1 | Insert found no free slot |
| rsp_slot | output | HASH_W | Result slot index |
| rsp_ctx | output | 32 | Context word |

## Verification
A wrong hash or probe step shows up on the very first insert: the returned slot is wrong. If the clear walk is incomplete, stale slots make the lookups that follow hit or stop early. A packing error appears in rsp_ctx on the same completion that reports the insert. A write made by a failed insert stays hidden until a later lookup stops at a slot it should have passed. To catch that, the bench keeps its own model of every slot and compares every response against it, so the wrong slot or context is reported one command later at the latest.

// File: rtl/obj_hash_pkg.sv
package obj_hash_pkg;
  localparam int CHAN_W = 5;
  localparam int INST_W = 20;
  localparam int ENG_W  = 2;

  typedef enum logic [1:0] {
    OP_INS  = 2'd0,
    OP_LOOK = 2'd1,
    OP_REM  = 2'd2,
    OP_NOP  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_CLR, S_IDLE, S_READ, S_CHECK, S_REM, S_FIN
  } state_e;

  // Build the context word for either layout.
  function automatic logic [31:0] pack_ctx(input logic alt,
                                           input logic [CHAN_W-1:0] chan,
                                           input logic [ENG_W-1:0] eng,
                                           input logic [INST_W-1:0] inst);
    logic [31:0] w;
    w = '0;
    w[15:0]  = inst[19:4];
    w[28:24] = chan;
    if (alt) begin
      w[21:20] = eng;
    end else begin
      w[17:16] = eng;
      w[31]    = 1'b1;
    end
    return w;
  endfunction

  function automatic logic [CHAN_W-1:0] ctx_chan(input logic [31:0] w);
    return w[28:24];
  endfunction
endpackage

// File: rtl/ohe_hash.sv
module ohe_hash #(
  parameter int HASH_W = 9
) (
  input  logic [31:0]                     handle,
  input  logic [obj_hash_pkg::CHAN_W-1:0] chan,
  output logic [HASH_W-1:0]               hash
);
  localparam int NSL = (32 + HASH_W - 1) / HASH_W;
  localparam int PW  = NSL * HASH_W;

  logic [PW-1:0]     padded;
  logic [HASH_W-1:0] part [NSL];

  assign padded = PW'(handle);

  for (genvar g = 0; g < NSL; g++) begin : g_fold
    if (g == 0) begin : g_first
      assign part[g] = padded[HASH_W-1:0];
    end else begin : g_next
      assign part[g] = part[g-1] ^ padded[g*HASH_W +: HASH_W];
    end
  end

  assign hash = part[NSL-1] ^ HASH_W'({chan, {(HASH_W-4){1'b0}}});
endmodule

// File: rtl/ohe_ram.sv
module ohe_ram #(
  parameter int AW = 9,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)      mem[addr] <= wdata;
    else if (re) rdata     <= mem[addr];
  end
endmodule

// File: rtl/ohe_ctrl.sv
module ohe_ctrl
  import obj_hash_pkg::*;
#(
  parameter int HASH_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_op,
  input  logic [31:0]         req_handle,
  input  logic [CHAN_W-1:0]   req_chan,
  input  logic [ENG_W-1:0]    req_engine,
  input  logic [INST_W-1:0]   req_inst,
  input  logic [HASH_W-1:0]   req_slot,
  input  logic                fmt_alt,
  input  logic [HASH_W-1:0]   hash_in,
  output logic                ram_we,
  output logic                ram_re,
  output logic [HASH_W-1:0]   ram_addr,
  output logic [63:0]         ram_wdata,
  input  logic [63:0]         ram_rdata,
  output logic                rsp_done,
  output logic                rsp_hit,
  output logic                rsp_full,
  output logic [HASH_W-1:0]   rsp_slot,
  output logic [31:0]         rsp_ctx,
  output logic [1:0]          cur_op_o,
  output logic                cur_alt_o,
  output logic                clearing
);
  state_e            state;
  logic [HASH_W-1:0] clr_idx, probe, start;
  op_e               cur_op;
  logic [31:0]       cur_handle, cur_ctx;
  logic [CHAN_W-1:0] cur_chan;
  logic              cur_alt;

  logic [31:0]       rd_handle, rd_ctx;
  logic              slot_free, key_match, wrapped, accept;
  logic [HASH_W-1:0] next_idx;

  assign rd_handle = ram_rdata[63:32];
  assign rd_ctx    = ram_rdata[31:0];
  assign slot_free = (rd_handle == 32'd0);
  assign key_match = (rd_handle == cur_handle) && (ctx_chan(rd_ctx) == cur_chan);
  assign next_idx  = probe + HASH_W'(1);
  assign wrapped   = (next_idx == start);

  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign clearing  = (state == S_CLR);
  assign cur_op_o  = cur_op;
  assign cur_alt_o = cur_alt;

  always_comb begin
    ram_we    = 1'b0;
    ram_re    = 1'b0;
    ram_addr  = probe;
    ram_wdata = '0;
    case (state)
      S_CLR: begin
        ram_we   = 1'b1;
        ram_addr = clr_idx;
      end
      S_READ: ram_re = 1'b1;
      S_CHECK: begin
        if (cur_op == OP_INS && slot_free) begin
          ram_we    = 1'b1;
          ram_wdata = {cur_handle, cur_ctx};
        end
      end
      S_REM: begin
        ram_we   = 1'b1;
        ram_addr = start;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_CLR;
      clr_idx    <= '0;
      probe      <= '0;
      start      <= '0;
      cur_op     <= OP_NOP;
      cur_handle <= '0;
      cur_chan   <= '0;
      cur_ctx    <= '0;
      cur_alt    <= 1'b0;
      rsp_done   <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_full   <= 1'b0;
      rsp_slot   <= '0;
      rsp_ctx    <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        S_CLR: begin
          clr_idx <= clr_idx + HASH_W'(1);
          if (&clr_idx) state <= S_IDLE;
        end
        S_IDLE: begin
          if (accept) begin
            cur_op     <= op_e'(req_op);
            cur_handle <= req_handle;
            cur_chan   <= req_chan;
            cur_alt    <= fmt_alt;
            cur_ctx    <= pack_ctx(fmt_alt, req_chan, req_engine, req_inst);
            if (op_e'(req_op) == OP_REM) begin
              start <= req_slot;
              probe <= req_slot;
              state <= S_REM;
            end else begin
              start <= hash_in;
              probe <= hash_in;
              if (op_e'(req_op) == OP_NOP || req_handle == 32'd0) state <= S_FIN;
              else state <= S_READ;
            end
          end
        end
        S_READ: state <= S_CHECK;
        S_CHECK: begin
          if (cur_op == OP_INS) begin
            if (slot_free) begin
              rsp_done <= 1'b1; rsp_hit <= 1'b1; rsp_full <= 1'b0;
              rsp_slot <= probe; rsp_ctx <= cur_ctx;
              state    <= S_IDLE;
            end else if (wrapped) begin
              rsp_done <= 1'b1; rsp_hit <= 1'b0; rsp_full <= 1'b1;
              rsp_slot <= start; rsp_ctx <= '0;
              state    <= S_IDLE;
            end else begin
              probe <= next_idx;
              state <= S_READ;
            end
          end else begin
            if (!slot_free && key_match) begin
              rsp_done <= 1'b1; rsp_hit <= 1'b1; rsp_full <= 1'b0;
              rsp_slot <= probe; rsp_ctx <= rd_ctx;
              state    <= S_IDLE;
            end else if (slot_free || wrapped) begin
              rsp_done <= 1'b1; rsp_hit <= 1'b0; rsp_full <= 1'b0;
              rsp_slot <= start; rsp_ctx <= '0;
              state    <= S_IDLE;
            end else begin
              probe <= next_idx;
              state <= S_READ;
            end
          end
        end
        S_REM: begin
          rsp_done <= 1'b1; rsp_hit <= 1'b1; rsp_full <= 1'b0;
          rsp_slot <= start; rsp_ctx <= '0;
          state    <= S_IDLE;
        end
        default: begin
          rsp_done <= 1'b1; rsp_hit <= 1'b0; rsp_full <= 1'b0;
          rsp_slot <= start; rsp_ctx <= '0;
          state    <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/obj_hash_engine.sv
module obj_hash_engine
  import obj_hash_pkg::*;
#(
  parameter int HASH_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_op,
  input  logic [31:0]         req_handle,
  input  logic [CHAN_W-1:0]   req_chan,
  input  logic [ENG_W-1:0]    req_engine,
  input  logic [INST_W-1:0]   req_inst,
  input  logic [HASH_W-1:0]   req_slot,
  input  logic                fmt_alt,
  output logic                rsp_done,
  output logic                rsp_hit,
  output logic                rsp_full,
  output logic [HASH_W-1:0]   rsp_slot,
  output logic [31:0]         rsp_ctx
);
  logic [HASH_W-1:0] start_hash;
  logic              ram_we, probe_rd;
  logic [HASH_W-1:0] ram_addr;
  logic [63:0]       ram_wdata, ram_rdata;
  logic [1:0]        cur_op;
  logic              cur_alt, clearing;

  ohe_hash #(.HASH_W(HASH_W)) u_hash (
    .handle(req_handle), .chan(req_chan), .hash(start_hash)
  );

  ohe_ram #(.AW(HASH_W), .DW(64)) u_ram (
    .clk(clk), .we(ram_we), .re(probe_rd), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );

  ohe_ctrl #(.HASH_W(HASH_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_handle(req_handle), .req_chan(req_chan), .req_engine(req_engine),
    .req_inst(req_inst), .req_slot(req_slot), .fmt_alt(fmt_alt),
    .hash_in(start_hash),
    .ram_we(ram_we), .ram_re(probe_rd), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .rsp_done(rsp_done), .rsp_hit(rsp_hit), .rsp_full(rsp_full),
    .rsp_slot(rsp_slot), .rsp_ctx(rsp_ctx),
    .cur_op_o(cur_op), .cur_alt_o(cur_alt), .clearing(clearing)
  );
endmodule

// File: rtl/ohe_chk.sv
module ohe_chk
  import obj_hash_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [1:0]  req_op,
  input logic [31:0] req_handle,
  input logic        rsp_done,
  input logic        rsp_hit,
  input logic        rsp_full,
  input logic [31:0] rsp_ctx,
  input logic        ram_we,
  input logic        probe_rd,
  input logic [1:0]  cur_op,
  input logic        cur_alt,
  input logic        clearing
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R10
  hit_full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !(rsp_hit && rsp_full));

  // R4
  full_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_full) |-> !$past(ram_we));

  // R8
  zero_no_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == OP_LOOK && req_handle == 32'd0) |=> !probe_rd);

  // R5
  legacy_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_hit && cur_op == OP_INS && !cur_alt) |-> rsp_ctx[31]);

  // R6
  alt_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_hit && cur_op == OP_INS && cur_alt) |-> !rsp_ctx[31]);

  // R11
  clear_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |-> !req_ready);
endmodule

bind obj_hash_engine ohe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_handle(req_handle), .rsp_done(rsp_done),
  .rsp_hit(rsp_hit), .rsp_full(rsp_full), .rsp_ctx(rsp_ctx),
  .ram_we(ram_we), .probe_rd(probe_rd), .cur_op(cur_op),
  .cur_alt(cur_alt), .clearing(clearing)
);

// File: tb/obj_hash_engine_bench.sv
`timescale 1ns/1ps
module obj_hash_engine_bench;
  localparam int HW = 5;
  localparam int N  = 1 << HW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, fmt_alt = 1'b0;
  logic [1:0] req_op = '0;
  logic [31:0] req_handle = '0;
  logic [4:0] req_chan = '0;
  logic [1:0] req_engine = '0;
  logic [19:0] req_inst = '0;
  logic [HW-1:0] req_slot = '0;
  logic rsp_done, rsp_hit, rsp_full;
  logic [HW-1:0] rsp_slot;
  logic [31:0] rsp_ctx;

  int checks = 0, failures = 0;
  logic [31:0] mh [N];
  logic [31:0] mc [N];

  always #2.5 clk = ~clk;

  obj_hash_engine #(.HASH_W(HW)) u_obj_hash_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_handle(req_handle), .req_chan(req_chan),
    .req_engine(req_engine), .req_inst(req_inst), .req_slot(req_slot),
    .fmt_alt(fmt_alt), .rsp_done(rsp_done), .rsp_hit(rsp_hit),
    .rsp_full(rsp_full), .rsp_slot(rsp_slot), .rsp_ctx(rsp_ctx)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // R1 R2: bitwise restatement of the fold and channel mix
  function automatic logic [HW-1:0] bh(input logic [31:0] h, input logic [4:0] ch);
    logic [HW-1:0] r = '0;
    for (int i = 0; i < 32; i++) r[i % HW] ^= h[i];
    for (int j = 0; j < 5; j++) if (j + HW - 4 < HW) r[j + HW - 4] ^= ch[j];
    return r;
  endfunction

  // R5 R6
  function automatic logic [31:0] bctx(input logic alt, input logic [4:0] ch,
                                       input logic [1:0] e, input logic [19:0] inst);
    if (alt) return ({27'd0, ch} << 24) | ({30'd0, e} << 20) | {16'd0, inst[19:4]};
    return 32'h8000_0000 | ({27'd0, ch} << 24) | ({30'd0, e} << 16) | {16'd0, inst[19:4]};
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [31:0] h, input logic [4:0] ch,
                        input logic [1:0] e, input logic [19:0] inst,
                        input logic [HW-1:0] sl, input logic alt, input string tag);
    logic eh = 0, ef = 0, fnd = 0;
    logic [HW-1:0] es;
    logic [31:0] ec = 0;
    int idx;
    es = bh(h, ch);
    if (op == 2'd0 && h != 0) begin
      for (int k = 0; k < N && !fnd; k++) begin
        idx = (int'(es) + k) % N;
        if (mh[idx] == 0) begin
          fnd = 1; mh[idx] = h; mc[idx] = bctx(alt, ch, e, inst);
          eh = 1; ec = mc[idx]; es = HW'(idx);
        end
      end
      if (!fnd) ef = 1;
    end else if (op == 2'd1 && h != 0) begin
      for (int k = 0; k < N && !fnd; k++) begin
        idx = (int'(es) + k) % N;
        if (mh[idx] == 0) fnd = 1;
        else if (mh[idx] == h && mc[idx][28:24] == ch) begin
          fnd = 1; eh = 1; ec = mc[idx]; es = HW'(idx);
        end
      end
    end else if (op == 2'd2) begin
      mh[sl] = 0; mc[sl] = 0; eh = 1; es = sl;
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = op; req_handle = h; req_chan = ch;
    req_engine = e; req_inst = inst; req_slot = sl; fmt_alt = alt;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready && !rsp_done, {tag, " R10 busy"}, {62'd0, req_ready, rsp_done}, 64'd0);
    while (!rsp_done) @(negedge clk);
    chk(rsp_hit == eh, {tag, " hit"}, 64'(rsp_hit), 64'(eh));
    chk(rsp_full == ef, {tag, " full"}, 64'(rsp_full), 64'(ef));
    chk(rsp_slot == es, {tag, " slot"}, 64'(rsp_slot), 64'(es));
    chk(rsp_ctx == ec, {tag, " ctx"}, 64'(rsp_ctx), 64'(ec));
    @(negedge clk);
    chk(!rsp_done, {tag, " R10 pulse"}, 64'(rsp_done), 64'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < N; i++) begin mh[i] = 0; mc[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!req_ready && !rsp_done, "R11 clear busy", {62'd0, req_ready, rsp_done}, 64'd0);
    cyc = 1;
    while (!req_ready && cyc < 1000) begin @(negedge clk); cyc++; end
    chk(cyc >= N - 1 && cyc <= N + 2, "R11 clear length", 64'(cyc), 64'(N));

    run_op(2'd1, 32'h0000_0077, 5'd0, 2'd0, 20'd0, '0, 0, "R11 empty lookup");
    run_op(2'd0, 32'h0000_0001, 5'd0, 2'd1, 20'h12340, '0, 0, "R1 R3 R5 insert");
    run_op(2'd0, 32'h0000_0020, 5'd0, 2'd2, 20'hABCD0, '0, 0, "R3 collision");
    run_op(2'd0, 32'hFFFF_FFFF, 5'd3, 2'd3, 20'hFFFFF, '0, 0, "R1 fold all ones");
    run_op(2'd1, 32'h0000_0020, 5'd0, 2'd0, 20'd0, '0, 0, "R7 lookup hit");
    run_op(2'd1, 32'h0000_0001, 5'd1, 2'd0, 20'd0, '0, 0, "R2 R7 channel miss");
    run_op(2'd0, 32'h0000_0001, 5'd1, 2'd1, 20'h00010, '0, 0, "R2 channel mix");
    run_op(2'd1, 32'h0000_0000, 5'd0, 2'd0, 20'd0, '0, 0, "R8 lookup zero");
    run_op(2'd0, 32'h0000_0000, 5'd2, 2'd1, 20'h55550, '0, 0, "R8 insert zero");
    run_op(2'd0, 32'h0BAD_0000, 5'd7, 2'd2, 20'h9F3A0, '0, 1, "R6 alt layout");
    run_op(2'd1, 32'h0BAD_0000, 5'd7, 2'd0, 20'd0, '0, 1, "R6 alt lookup");
    run_op(2'd3, 32'h0000_0009, 5'd0, 2'd0, 20'd0, '0, 0, "R10 nop");
    run_op(2'd2, 32'h0, 5'd0, 2'd0, 20'd0, HW'(1), 0, "R9 remove");
    run_op(2'd1, 32'h0000_0001, 5'd0, 2'd0, 20'd0, '0, 0, "R9 removed miss");
    run_op(2'd1, 32'h0000_0020, 5'd0, 2'd0, 20'd0, '0, 0, "R7 stop at free");

    for (int s = 0; s < N; s++) run_op(2'd2, 32'h0, 5'd0, 2'd0, 20'd0, HW'(s), 0, "R9 flush");
    for (int s = 1; s <= N; s++) run_op(2'd0, 32'(s), 5'd0, 2'(s), 20'(s * 16), '0, 0, "R3 fill");
    run_op(2'd0, 32'd1000, 5'd4, 2'd1, 20'h11110, '0, 0, "R4 full");
    run_op(2'd1, 32'd1000, 5'd4, 2'd0, 20'd0, '0, 0, "R4 R7 wrap miss");
    run_op(2'd1, 32'd5, 5'd0, 2'd0, 20'd0, '0, 0, "R4 intact");

    for (int i = 0; i < 400; i++) begin
      logic [1:0] op;
      logic [31:0] h;
      op = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 5) == 0) op = 2'd2;
      h = ($urandom_range(0, 9) == 0) ? 32'd0 : 32'($urandom_range(1, 40)) << ($urandom_range(0, 2) * 5);
      run_op(op, h, 5'($urandom_range(0, 3)), 2'($urandom), 20'($urandom),
             HW'($urandom), 1'($urandom), "R3 R7 R9 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule